// File: doc/BRIEF.md
# Parallel Backplane Bus Requester

This block wins and gives back mastership of an arbitrated parallel backplane for a local processor. It watches the processor's cycle qualifiers and a handful of control bits. When the board does not own the bus and something needs it, the block raises a bus request on a level chosen by software. It then waits for the arbiter's grant and for the previous owner to let go of bus-busy. After that it drives bus-busy itself and tells the master interface, through a mastership flag, that transfers may begin.

Requesting and keeping the bus follow two separate sets of conditions. Any of these can start a request: a processor cycle decoded for the backplane (program space, data space or interrupt acknowledge), the software "want bus" bit, or a multi-address locked read-modify-write aimed at local memory while the RMW-wait bit is set. Mastership is kept while any hold condition is true. Once none is true, the block releases bus-busy and returns to idle. The grant, bus-busy and the other masters' request lines pass through two-flop synchronisers before the state machine uses them.

Top module: `bus_requester`

## Requirements
- R1: While the synchronous reset `rst_n` is low, then on the first clock edge, `breq_o` is all zero and `bbsy_o` and `master_o` are low.
- R2: A program-space, data-space or interrupt-acknowledge cycle with `cyc_remote_i` high starts a request one clock later. The same cycles with `cyc_remote_i` low start no request.
- R3: Setting `ctl_wantbus_i` starts a request one clock later, with no processor cycle pending.
- R4: `rmw_local_i` starts a request only when `ctl_rmw_wait_i` is set. With the wait bit clear it starts none.
- R5: The request is one-hot. Bit `ctl_level_i` of `breq_o` is high (level 0 is bit 0, level 3 is bit 3), and all other bits are low.
- R6: While `ctl_defer_i` is set and any bit of `others_req_i` is seen high, no request is started. A pending trigger starts its request three clocks after the last such line goes low.
- R7: When `grant_i` rises while `busy_i` is low, `bbsy_o` and `master_o` go high and `breq_o` goes to zero three clocks later. Until then the request stays up.
- R8: When a grant arrives while `busy_i` is high, the request is kept. Bus-busy is taken three clocks after `busy_i` falls.
- R9: Mastership is kept while any of these is true: `cyc_active_i`, `ctl_keep_i`, `ctl_wantbus_i`, `rmw_remote_i`, or `rmw_local_i` together with `ctl_rmw_wait_i`. One clock after all of them are false, `bbsy_o` and `master_o` drop.
- R10: With `ctl_rel_done_i` clear, mastership is also kept while no other request line is seen. It is released three clocks after any `others_req_i` bit rises.
- R11: `master_o` is high exactly while `bbsy_o` is high.
- R12: No request is driven while the board holds bus-busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_prog_i | input | 1 | Processor program-space cycle |
| cyc_data_i | input | 1 | Processor data-space cycle |
| cyc_iack_i | input | 1 | Processor interrupt-acknowledge cycle |
| cyc_remote_i | input | 1 | Current cycle decoded as bound for the backplane |
| cyc_active_i | input | 1 | A backplane cycle is in progress |
| rmw_remote_i | input | 1 | Locked read-modify-write to the backplane in progress |
| rmw_local_i | input | 1 | Multi-address locked read-modify-write aimed at local memory |
| ctl_wantbus_i | input | 1 | Software "want bus" bit |
| ctl_keep_i | input | 1 | Never-release bit |
| ctl_rel_done_i | input | 1 | Release-when-done bit |
| ctl_defer_i | input | 1 | Request only when no other request is active |
| ctl_rmw_wait_i | input | 1 | RMW-wait bit |
| ctl_level_i | input | 2 | Request level select |
| others_req_i | input | 4 | Other masters' bus request lines, active high |
| grant_i | input | 1 | Bus grant arriving at this board, active high |
| busy_i | input | 1 | Bus-busy driven by other masters, active high |
| breq_o | output | 4 | Bus request, one-hot on the selected level |
| bbsy_o | output | 1 | Bus-busy driven by this board |
| master_o | output | 1 | Mastership held, to the master interface |

## Verification
A trigger reaches `breq_o` one clock later, because only the state register lies in that path. Results that depend on `grant_i`, `busy_i` or `others_req_i` are due three clocks later: two synchroniser flops and then the state register. Dropping the last hold condition releases the bus one clock later. Each stimulus task files its expected output values with the number of the cycle they are due in. A monitor samples on the falling edge of that exact cycle, so a result that arrives one cycle early or late is reported. For the three-cycle paths, the monitor also checks the cycle just before, to confirm nothing moved too soon.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OWN  = 2'd3
  } req_state_t;

  // Anything that makes the board want the bus.
  function automatic logic req_trigger(
    input logic prog, input logic data, input logic iack, input logic remote,
    input logic wantbus, input logic rmw_local, input logic rmw_wait);
    return (remote & (prog | data | iack)) | wantbus | (rmw_local & rmw_wait);
  endfunction

  // Anything that makes the board keep the bus once it owns it.
  function automatic logic hold_cond(
    input logic cyc_active, input logic rel_done, input logic others_any,
    input logic keep, input logic wantbus, input logic rmw_remote,
    input logic rmw_local, input logic rmw_wait);
    return cyc_active | (~rel_done & ~others_any) | keep | wantbus |
           rmw_remote | (rmw_local & rmw_wait);
  endfunction

endpackage

// File: rtl/bus_req_sync.sv
module bus_req_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/bus_req_cond.sv
module bus_req_cond #(
  parameter int NLEV = 4
) (
  input  logic            cyc_prog_i,
  input  logic            cyc_data_i,
  input  logic            cyc_iack_i,
  input  logic            cyc_remote_i,
  input  logic            cyc_active_i,
  input  logic            rmw_remote_i,
  input  logic            rmw_local_i,
  input  logic            ctl_wantbus_i,
  input  logic            ctl_keep_i,
  input  logic            ctl_rel_done_i,
  input  logic            ctl_defer_i,
  input  logic            ctl_rmw_wait_i,
  input  logic [NLEV-1:0] others_s_i,
  output logic            trig_o,
  output logic            hold_o,
  output logic            defer_o
);
  import bus_req_pkg::*;

  logic others_any;
  assign others_any = |others_s_i;

  assign trig_o  = req_trigger(cyc_prog_i, cyc_data_i, cyc_iack_i, cyc_remote_i,
                               ctl_wantbus_i, rmw_local_i, ctl_rmw_wait_i);
  assign hold_o  = hold_cond(cyc_active_i, ctl_rel_done_i, others_any, ctl_keep_i,
                             ctl_wantbus_i, rmw_remote_i, rmw_local_i, ctl_rmw_wait_i);
  assign defer_o = ctl_defer_i & others_any;

endmodule

// File: rtl/bus_req_fsm.sv
module bus_req_fsm #(
  parameter int NLEV = 4,
  localparam int LW  = $clog2(NLEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            hold_i,
  input  logic            defer_i,
  input  logic            grant_s_i,
  input  logic            busy_s_i,
  input  logic [LW-1:0]   level_i,
  output logic [NLEV-1:0] breq_o,
  output logic            bbsy_o,
  output logic            master_o
);
  import bus_req_pkg::*;

  req_state_t state_q, state_d;
  logic [LW-1:0] lvl_q;
  logic          start_w;
  logic          requesting;

  assign start_w = trig_i & ~defer_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_w)   state_d = ST_REQ;
      ST_REQ:  if (grant_s_i) state_d = busy_s_i ? ST_WAIT : ST_OWN;
      ST_WAIT: if (!busy_s_i) state_d = ST_OWN;
      ST_OWN:  if (!hold_i)   state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_w) lvl_q <= level_i;
    end
  end

  assign requesting = (state_q == ST_REQ) || (state_q == ST_WAIT);

  for (genvar i = 0; i < NLEV; i++) begin : g_lvl
    assign breq_o[i] = requesting && (lvl_q == LW'(i));
  end

  assign bbsy_o   = (state_q == ST_OWN);
  assign master_o = (state_q == ST_OWN);

endmodule

// File: rtl/bus_requester.sv
module bus_requester #(
  parameter int NLEV    = 4,
  parameter int SYNC_FF = 2,
  localparam int LW     = $clog2(NLEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_prog_i,
  input  logic            cyc_data_i,
  input  logic            cyc_iack_i,
  input  logic            cyc_remote_i,
  input  logic            cyc_active_i,
  input  logic            rmw_remote_i,
  input  logic            rmw_local_i,
  input  logic            ctl_wantbus_i,
  input  logic            ctl_keep_i,
  input  logic            ctl_rel_done_i,
  input  logic            ctl_defer_i,
  input  logic            ctl_rmw_wait_i,
  input  logic [LW-1:0]   ctl_level_i,
  input  logic [NLEV-1:0] others_req_i,
  input  logic            grant_i,
  input  logic            busy_i,
  output logic [NLEV-1:0] breq_o,
  output logic            bbsy_o,
  output logic            master_o
);

  localparam int SW = NLEV + 2;

  logic [SW-1:0]   async_w, sync_w;
  logic [NLEV-1:0] others_s;
  logic            grant_s, busy_s;
  logic            trig_w, hold_w, defer_w;

  assign async_w = {others_req_i, grant_i, busy_i};
  assign {others_s, grant_s, busy_s} = sync_w;

  bus_req_sync #(.W(SW), .STAGES(SYNC_FF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_w),
    .q_o   (sync_w)
  );

  bus_req_cond #(.NLEV(NLEV)) u_cond (
    .cyc_prog_i     (cyc_prog_i),
    .cyc_data_i     (cyc_data_i),
    .cyc_iack_i     (cyc_iack_i),
    .cyc_remote_i   (cyc_remote_i),
    .cyc_active_i   (cyc_active_i),
    .rmw_remote_i   (rmw_remote_i),
    .rmw_local_i    (rmw_local_i),
    .ctl_wantbus_i  (ctl_wantbus_i),
    .ctl_keep_i     (ctl_keep_i),
    .ctl_rel_done_i (ctl_rel_done_i),
    .ctl_defer_i    (ctl_defer_i),
    .ctl_rmw_wait_i (ctl_rmw_wait_i),
    .others_s_i     (others_s),
    .trig_o         (trig_w),
    .hold_o         (hold_w),
    .defer_o        (defer_w)
  );

  bus_req_fsm #(.NLEV(NLEV)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_w),
    .hold_i    (hold_w),
    .defer_i   (defer_w),
    .grant_s_i (grant_s),
    .busy_s_i  (busy_s),
    .level_i   (ctl_level_i),
    .breq_o    (breq_o),
    .bbsy_o    (bbsy_o),
    .master_o  (master_o)
  );

endmodule

// File: rtl/bus_requester_chk.sv
module bus_requester_chk #(
  parameter int NLEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLEV-1:0] breq_o,
  input logic            bbsy_o,
  input logic            master_o,
  input logic            hold_w,
  input logic            defer_w,
  input logic            busy_s
);

  // R1: one edge after reset is seen, everything is released
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (breq_o == '0 && !bbsy_o && !master_o));

  // R5: never more than one request level at a time
  a_r5_onehot_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(breq_o));

  // R6: while deferred and idle, no request starts
  a_r6_defer_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_o == '0 && !bbsy_o && defer_w) |=> (breq_o == '0));

  // R7: bus-busy is taken only after a request was up
  a_r7_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy_o) |-> ($past(breq_o) != '0));

  // R8: bus-busy is taken only when the other owner had let go
  a_r8_wait_busy_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy_o) |-> !$past(busy_s));

  // R9: a live hold condition keeps the bus
  a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bbsy_o && hold_w) |=> bbsy_o);

  // R11: mastership flag tracks bus-busy
  a_r11_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    master_o == bbsy_o);

  // R12: no request while owning
  a_r12_no_req_owned: assert property (@(posedge clk) disable iff (!rst_n)
    bbsy_o |-> (breq_o == '0));

endmodule

bind bus_requester bus_requester_chk #(.NLEV(NLEV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .breq_o   (breq_o),
  .bbsy_o   (bbsy_o),
  .master_o (master_o),
  .hold_w   (hold_w),
  .defer_w  (defer_w),
  .busy_s   (busy_s)
);

// File: tb/bus_requester_tb.sv
module bus_requester_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_prog, cyc_data, cyc_iack, cyc_remote, cyc_active;
  logic       rmw_remote, rmw_local;
  logic       wantbus, keep, rel_done, defer, rmw_wait;
  logic [1:0] level;
  logic [3:0] others;
  logic       grant, busy;
  logic [3:0] breq;
  logic       bbsy, master;

  always #2 clk = ~clk;  // 250 MHz

  bus_requester u_dut (
    .clk(clk), .rst_n(rst_n),
    .cyc_prog_i(cyc_prog), .cyc_data_i(cyc_data), .cyc_iack_i(cyc_iack),
    .cyc_remote_i(cyc_remote), .cyc_active_i(cyc_active),
    .rmw_remote_i(rmw_remote), .rmw_local_i(rmw_local),
    .ctl_wantbus_i(wantbus), .ctl_keep_i(keep), .ctl_rel_done_i(rel_done),
    .ctl_defer_i(defer), .ctl_rmw_wait_i(rmw_wait), .ctl_level_i(level),
    .others_req_i(others), .grant_i(grant), .busy_i(busy),
    .breq_o(breq), .bbsy_o(bbsy), .master_o(master)
  );

  typedef struct {
    int         due;
    logic [3:0] breq;
    logic       bbsy;
    logic       mst;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected one-hot request for a level (R5 encoding)
  function automatic logic [3:0] lvl_bit(input int l);
    return 4'b0001 << l;
  endfunction

  task automatic expect_at(input int d, input logic [3:0] b, input logic bb,
                           input logic m, input string tag);
    exp_t e;
    e.due = cyc + d; e.breq = b; e.bbsy = bb; e.mst = m; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // Monitor: compare on the falling edge of the due cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (e.due != cyc || breq !== e.breq || bbsy !== e.bbsy || master !== e.mst) begin
        errors++;
        $display("FAIL %s cyc=%0d: got breq=%b bbsy=%b mst=%b, expected breq=%b bbsy=%b mst=%b (due %0d)",
                 e.tag, cyc, breq, bbsy, master, e.breq, e.bbsy, e.mst, e.due);
      end
    end
  end

  // Grant with the bus free: owned three clocks later
  task automatic acquire(input logic [3:0] b, input string tag);
    grant = 1'b1;
    expect_at(2, b, 1'b0, 1'b0, tag);
    expect_at(3, 4'b0, 1'b1, 1'b1, tag);
    step(3);
    grant = 1'b0;
    step(3);
  endtask

  initial begin
    rst_n = 1'b0;
    {cyc_prog, cyc_data, cyc_iack, cyc_remote, cyc_active} = '0;
    {rmw_remote, rmw_local, wantbus, keep, defer, rmw_wait} = '0;
    rel_done = 1'b1; level = 2'd0; others = 4'b0; grant = 1'b0; busy = 1'b0;
    step(1);
    wantbus = 1'b1;                       // R1: ignored during reset
    step(2);
    expect_at(0, 4'b0, 1'b0, 1'b0, "R1");
    step(1);
    wantbus = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(2);

    // R2 negative: program cycle not bound for the backplane
    cyc_prog = 1'b1;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R2");
    step(2);
    // R2/R5: same cycle, remote, level 2
    level = 2'd2; cyc_remote = 1'b1; cyc_active = 1'b1;
    expect_at(1, lvl_bit(2), 1'b0, 1'b0, "R5");
    step(1);
    acquire(lvl_bit(2), "R7");
    expect_at(0, 4'b0, 1'b1, 1'b1, "R12");
    step(1);
    cyc_prog = 1'b0; cyc_remote = 1'b0; cyc_active = 1'b0;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R9");
    step(3);

    // R3 with R8: want-bus bit, grant while bus busy
    level = 2'd0; wantbus = 1'b1;
    expect_at(1, lvl_bit(0), 1'b0, 1'b0, "R3");
    step(1);
    grant = 1'b1; busy = 1'b1;
    expect_at(3, lvl_bit(0), 1'b0, 1'b0, "R8");
    step(3);
    grant = 1'b0;
    step(2);
    expect_at(0, lvl_bit(0), 1'b0, 1'b0, "R8");
    step(1);
    busy = 1'b0;
    expect_at(2, lvl_bit(0), 1'b0, 1'b0, "R8");
    expect_at(3, 4'b0, 1'b1, 1'b1, "R8");
    step(4);
    expect_at(0, 4'b0, 1'b1, 1'b1, "R9");
    step(1);
    wantbus = 1'b0;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R9");
    step(3);

    // R4: local RMW without, then with, the wait bit
    rmw_local = 1'b1;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R4");
    step(2);
    rmw_local = 1'b0; level = 2'd3;
    step(1);
    rmw_local = 1'b1; rmw_wait = 1'b1;
    expect_at(1, lvl_bit(3), 1'b0, 1'b0, "R4");
    step(1);
    acquire(lvl_bit(3), "R4");
    expect_at(0, 4'b0, 1'b1, 1'b1, "R9");
    step(1);
    rmw_local = 1'b0;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R9");
    step(3);
    rmw_wait = 1'b0;

    // R6: defer while another master requests
    level = 2'd1; defer = 1'b1; others = 4'b0010;
    step(3);
    wantbus = 1'b1;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R6");
    step(3);
    expect_at(0, 4'b0, 1'b0, 1'b0, "R6");
    step(1);
    others = 4'b0;
    expect_at(2, 4'b0, 1'b0, 1'b0, "R6");
    expect_at(3, lvl_bit(1), 1'b0, 1'b0, "R6");
    step(3);
    acquire(lvl_bit(1), "R7");

    // R10: release-when-done clear keeps the bus until someone asks
    rel_done = 1'b0; wantbus = 1'b0;
    expect_at(1, 4'b0, 1'b1, 1'b1, "R10");
    step(3);
    expect_at(0, 4'b0, 1'b1, 1'b1, "R10");
    step(1);
    others = 4'b0100;
    expect_at(2, 4'b0, 1'b1, 1'b1, "R10");
    expect_at(3, 4'b0, 1'b0, 1'b0, "R10");
    step(4);
    others = 4'b0; rel_done = 1'b1; defer = 1'b0;
    step(3);

    // R9: never-release bit, then remote RMW
    level = 2'd0; wantbus = 1'b1;
    expect_at(1, lvl_bit(0), 1'b0, 1'b0, "R3");
    step(1);
    acquire(lvl_bit(0), "R7");
    keep = 1'b1; wantbus = 1'b0; others = 4'b1000;
    step(5);
    expect_at(0, 4'b0, 1'b1, 1'b1, "R9");
    step(1);
    keep = 1'b0; rmw_remote = 1'b1;
    expect_at(1, 4'b0, 1'b1, 1'b1, "R9");
    step(2);
    rmw_remote = 1'b0;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R9");
    step(2);
    others = 4'b0;
    step(2);

    // R2: interrupt acknowledge and data cycles bound for the backplane
    level = 2'd3; cyc_iack = 1'b1; cyc_remote = 1'b1; cyc_active = 1'b1;
    expect_at(1, lvl_bit(3), 1'b0, 1'b0, "R2");
    step(1);
    acquire(lvl_bit(3), "R2");
    cyc_iack = 1'b0; cyc_remote = 1'b0; cyc_active = 1'b0;
    expect_at(1, 4'b0, 1'b0, 1'b0, "R9");
    step(3);
    level = 2'd2; cyc_data = 1'b1; cyc_remote = 1'b1;
    expect_at(1, lvl_bit(2), 1'b0, 1'b0, "R2");
    step(1);
    cyc_data = 1'b0; cyc_remote = 1'b0;
    grant = 1'b1;
    expect_at(3, 4'b0, 1'b1, 1'b1, "R7");
    expect_at(4, 4'b0, 1'b0, 1'b0, "R9");
    step(3);
    grant = 1'b0;
    step(4);

    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 queue: %0d expected items never compared, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule